// File: doc/BRIEF.md
# Serial Paged-Memory Read Slave

This block is a serial read-only slave in front of a small on-chip paged store. The store has a main array of 528-byte pages plus two separate page-sized buffers. A host lowers the chip select and shifts a command in on the data input, one bit per rising serial clock edge. The command is an 8-bit opcode, a 24-bit address field and a run of don't-care bits. The block then streams the addressed bytes out, most significant bit first, for as long as the host keeps clocking. An internal pointer advances through the bytes. In the main array it carries across page boundaries, so one command can read any length of data.

Two read categories exist, each selected by its own opcodes. The tolerant category drives the first data bit as soon as the last header bit has been taken, and it moves to the next bit on rising edges. This makes it indifferent to the level the clock idles at. The SPI category behaves like SPI modes 0 and 3. It drives its first bit on the falling edge after the header and changes bits on falling edges. The serial pins are oversampled by the block clock through a synchronizer. The stored bytes are loaded through a backdoor write port that is separate from the serial interface.

Top module: `pgrd_top`

## Requirements
- R1: While `csN` is low, each rising `sck` edge shifts one bit of `si` in. Opcode, address field and output data all travel most significant bit first.
- R2: For main-array reads, address field bits [21:10] give the page number and bits [9:0] the byte offset, and bits [23:22] are ignored. The page number is used modulo `NUM_PAGES`. Opcodes 0xE8 and 0x68 read the array and are followed by 32 don't-care bits.
- R3: A main-array read returns the addressed byte and then the following bytes of the same page. After offset 527 it moves to offset 0 of the next page.
- R4: Stepping past offset 527 of the last page (`NUM_PAGES`-1) continues at page 0, offset 0.
- R5: Opcodes 0xD4 and 0x54 read buffer 1, and 0xD6 and 0x56 read buffer 2. The byte offset is in address bits [9:0], followed by 8 don't-care bits. Offset 527 is followed by offset 0 of the same buffer.
- R6: A starting byte offset above 527 is treated as offset 0.
- R7: For opcodes 0xE8, 0xD4 and 0xD6, `soEn` rises and the first bit appears within the high phase that follows the rising edge carrying the last don't-care bit. Each later rising edge moves to the next bit.
- R8: For opcodes 0x68, 0x54 and 0x56, `soEn` stays low until the first falling edge after the header. That edge drives the first bit, and each later falling edge drives the next bit. This holds whether `sck` idles low or high.
- R9: `soEn` is low in the cycle after `csN` goes high. Raising `csN` abandons any command, and the next low period decodes a fresh command.
- R10: An opcode other than the six listed leaves `soEn` low until `csN` rises, however many clocks follow.
- R11: During and after reset `soEn` and `so` are low.
- R12: A backdoor write stores `bdData` on a rising `clk` while `bdWe` is high. `bdSel` 0 selects array page `bdPage`, 1 selects buffer 1 and 2 selects buffer 2, and `bdOffs` gives the byte offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, low when not driving |
| soEn | output | 1 | Output enable for the `so` pad driver |
| bdWe | input | 1 | Backdoor write enable |
| bdSel | input | 2 | Backdoor target: 0 array, 1 buffer 1, 2 buffer 2 |
| bdPage | input | 12 | Backdoor page number (array only) |
| bdOffs | input | 10 | Backdoor byte offset |
| bdData | input | 8 | Backdoor write data |

## Verification
Every serial pin passes through two synchronizer flops and one edge-detect register before it acts. An output change therefore shows on `so`/`soEn` three block clocks after the `sck` edge that causes it, whether that is a first bit, a next bit or a tolerant-mode start. The bench holds each `sck` level for eight block clocks and samples at the falling `clk` edge just before it moves `sck` again. Each bit is therefore read well after it is due and before the next change. `soEn` is gated directly by the raw `csN`, so the bench checks it one block clock after raising chip select.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  localparam int PAGE_BYTES = 528;
  localparam int OFFS_W     = 10;
  localparam int PAGE_FLD_W = 12;
  localparam int ADDR_FLD_W = 24;
  localparam int OPC_W      = 8;
  localparam int ARR_DUMMY  = 32;
  localparam int BUF_DUMMY  = 8;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0,
    SRC_BUF1  = 2'd1,
    SRC_BUF2  = 2'd2
  } src_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic latchAddr;
    src_e src;
    logic startOut;
    logic advance;
  } strobe_t;

  typedef struct packed {
    logic valid;
    src_e src;
    logic tolerant;
  } opinfo_t;

  function automatic opinfo_t decodeOp(input logic [OPC_W-1:0] op);
    opinfo_t d;
    d = '{valid: 1'b0, src: SRC_ARRAY, tolerant: 1'b0};
    case (op)
      8'hE8: d = '{valid: 1'b1, src: SRC_ARRAY, tolerant: 1'b1};
      8'h68: d = '{valid: 1'b1, src: SRC_ARRAY, tolerant: 1'b0};
      8'hD4: d = '{valid: 1'b1, src: SRC_BUF1,  tolerant: 1'b1};
      8'h54: d = '{valid: 1'b1, src: SRC_BUF1,  tolerant: 1'b0};
      8'hD6: d = '{valid: 1'b1, src: SRC_BUF2,  tolerant: 1'b1};
      8'h56: d = '{valid: 1'b1, src: SRC_BUF2,  tolerant: 1'b0};
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pgrd_sync.sv
module pgrd_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg <= {STAGES{RST_VAL}};
    else       stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
  import pgrd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csS,
  input  logic             sckS,
  input  logic [OPC_W-1:0] opcode,
  output strobe_t          str
);
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_WAITFALL, ST_STREAM, ST_DEAD} st_e;

  localparam int ARR_HDR  = OPC_W + ADDR_FLD_W + ARR_DUMMY;
  localparam int BUF_HDR  = OPC_W + ADDR_FLD_W + BUF_DUMMY;
  localparam int CNT_W    = $clog2(ARR_HDR + 1);
  localparam logic [CNT_W-1:0] OPC_CNT  = CNT_W'(OPC_W);
  localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(OPC_W + ADDR_FLD_W - 1);

  st_e              state;
  logic [CNT_W-1:0] cnt;
  opinfo_t          info;
  opinfo_t          dec;
  logic             sckPrev;
  logic             sckRise, sckFall, outEdge;
  logic [CNT_W-1:0] hdrLast;

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign dec     = decodeOp(opcode);
  assign hdrLast = (info.src == SRC_ARRAY) ? CNT_W'(ARR_HDR - 1) : CNT_W'(BUF_HDR - 1);
  assign outEdge = info.tolerant ? sckRise : sckFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      info    <= '{valid: 1'b0, src: SRC_ARRAY, tolerant: 1'b0};
      sckPrev <= 1'b0;
    end else begin
      sckPrev <= sckS;
      if (csS) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            state <= ST_HDR;
            cnt   <= '0;
          end
          ST_HDR: if (sckRise) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == OPC_CNT) begin
              // opcode sits complete in the shifter at the ninth bit
              info <= dec;
              if (!dec.valid) state <= ST_DEAD;
            end else if (cnt == hdrLast) begin
              state <= info.tolerant ? ST_STREAM : ST_WAITFALL;
            end
          end
          ST_WAITFALL: if (sckFall) state <= ST_STREAM;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    str       = '0;
    str.clear = csS;
    str.src   = info.src;
    if (!csS) begin
      case (state)
        ST_HDR: if (sckRise) begin
          str.shiftIn   = 1'b1;
          str.latchAddr = (cnt == ADDR_CNT);
          str.startOut  = (cnt == hdrLast) && info.tolerant;
        end
        ST_WAITFALL: str.startOut = sckFall;
        ST_STREAM:   str.advance  = outEdge;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pgrd_dpath.sv
module pgrd_dpath
  import pgrd_pkg::*;
#(
  parameter int NUM_PAGES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               str,
  input  logic                  siS,
  input  logic                  bdWe,
  input  logic [1:0]            bdSel,
  input  logic [PAGE_FLD_W-1:0] bdPage,
  input  logic [OFFS_W-1:0]     bdOffs,
  input  logic [7:0]            bdData,
  output logic [OPC_W-1:0]      opcode,
  output logic                  active,
  output logic                  soBit
);
  localparam int PG_W  = $clog2(NUM_PAGES);
  localparam int SLOTS = NUM_PAGES + 2;
  localparam int DEPTH = SLOTS * PAGE_BYTES;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [OFFS_W-1:0] LAST_OFF = OFFS_W'(PAGE_BYTES - 1);

  function automatic logic [IDX_W-1:0] slotIdx(input logic [1:0] sel,
                                               input logic [PG_W-1:0] pg,
                                               input logic [OFFS_W-1:0] off);
    int slot;
    slot = (sel == 2'd0) ? int'(pg) : NUM_PAGES + int'(sel) - 1;
    return IDX_W'(slot * PAGE_BYTES + int'(off));
  endfunction

  logic [7:0]              mem [DEPTH];
  logic [ADDR_FLD_W-2:0]   shreg;
  logic [ADDR_FLD_W-1:0]   addrIn;
  src_e                    curSrc;
  logic [PG_W-1:0]         curPage;
  logic [OFFS_W-1:0]       curOff;
  logic [2:0]              bitIdx;
  logic [7:0]              curByte;
  logic                    unusedBits;

  assign addrIn     = {shreg, siS};
  assign opcode     = shreg[OPC_W-1:0];
  assign unusedBits = ^{bdPage[PAGE_FLD_W-1:PG_W], addrIn[ADDR_FLD_W-1:OFFS_W+PG_W]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg   <= '0;
      curSrc  <= SRC_ARRAY;
      curPage <= '0;
      curOff  <= '0;
      bitIdx  <= '0;
      active  <= 1'b0;
    end else if (str.clear) begin
      shreg  <= '0;
      active <= 1'b0;
    end else begin
      if (str.shiftIn) shreg <= addrIn[ADDR_FLD_W-2:0];
      if (str.latchAddr) begin
        curSrc  <= str.src;
        curPage <= addrIn[OFFS_W +: PG_W];
        curOff  <= (addrIn[OFFS_W-1:0] > LAST_OFF) ? '0 : addrIn[OFFS_W-1:0];
      end
      if (str.startOut) begin
        active <= 1'b1;
        bitIdx <= '0;
      end else if (str.advance) begin
        if (bitIdx == 3'd7) begin
          bitIdx <= '0;
          if (curOff == LAST_OFF) begin
            curOff <= '0;
            if (curSrc == SRC_ARRAY) curPage <= curPage + PG_W'(1);
          end else begin
            curOff <= curOff + OFFS_W'(1);
          end
        end else begin
          bitIdx <= bitIdx + 3'd1;
        end
      end
    end
  end

  // backdoor load port; code 3 is not a target
  always_ff @(posedge clk) begin
    if (bdWe && bdSel != 2'd3)
      mem[slotIdx(bdSel, bdPage[PG_W-1:0], bdOffs)] <= bdData;
  end

  assign curByte = mem[slotIdx(curSrc, curPage, curOff)];
  assign soBit   = curByte[3'd7 - bitIdx];
endmodule

// File: rtl/pgrd_top.sv
module pgrd_top
  import pgrd_pkg::*;
#(
  parameter int NUM_PAGES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        si,
  output logic        so,
  output logic        soEn,
  input  logic        bdWe,
  input  logic [1:0]  bdSel,
  input  logic [11:0] bdPage,
  input  logic [9:0]  bdOffs,
  input  logic [7:0]  bdData
);
  logic [2:0]       pinS;
  strobe_t          str;
  logic [OPC_W-1:0] opcode;
  logic             active, soBit;

  pgrd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .d({csN, sck, si}), .q(pinS)
  );

  pgrd_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csS(pinS[2]), .sckS(pinS[1]),
    .opcode(opcode), .str(str)
  );

  pgrd_dpath #(.NUM_PAGES(NUM_PAGES)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .siS(pinS[0]),
    .bdWe(bdWe), .bdSel(bdSel), .bdPage(bdPage), .bdOffs(bdOffs), .bdData(bdData),
    .opcode(opcode), .active(active), .soBit(soBit)
  );

  assign so   = active & soBit;
  assign soEn = active & ~csN;
endmodule

// File: rtl/pgrd_chk.sv
module pgrd_chk #(
  parameter int LAT = 3  // synchronizer stages plus edge register
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic so,
  input logic soEn
);
  assert_reset_quiet_R11: assert property (@(posedge clk) !rstN |=> (!soEn && !so));

  assert_select_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    soEn |-> !$past(csN, LAT + 1));

  // data only moves in response to a serial clock edge (R3, R5)
  assert_data_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (soEn && $past(soEn) && so != $past(so)) |-> ($past(sck, LAT) != $past(sck, LAT + 1)));

  // output start follows a serial clock edge in either category (R7 too)
  assert_start_on_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soEn) |-> ($past(sck, LAT) != $past(sck, LAT + 1)));
endmodule

bind pgrd_top pgrd_chk uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .so(so), .soEn(soEn)
);

// File: tb/sim_pgrd_top.sv
module sim_pgrd_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NP = 4;
  localparam int PB = 528;
  localparam int NVEC = 8;
  // {opcode, page, offset, byte count, sck idles high}
  localparam logic [36:0] VEC [NVEC] = '{
    {8'hE8, 12'd0, 10'd0,   6'd4, 1'b0},
    {8'h68, 12'd1, 10'd525, 6'd6, 1'b0},
    {8'hE8, 12'd3, 10'd526, 6'd4, 1'b1},
    {8'hD4, 12'd0, 10'd100, 6'd3, 1'b0},
    {8'h56, 12'd0, 10'd526, 6'd4, 1'b1},
    {8'hD6, 12'd0, 10'd0,   6'd2, 1'b0},
    {8'h54, 12'd0, 10'd700, 6'd2, 1'b0},
    {8'h68, 12'd2, 10'd900, 6'd2, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic bdWe = 1'b0;
  logic [1:0] bdSel = '0;
  logic [11:0] bdPage = '0;
  logic [9:0] bdOffs = '0;
  logic [7:0] bdData = '0;
  logic so, soEn;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  pgrd_top #(.NUM_PAGES(NP)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so), .soEn(soEn),
    .bdWe(bdWe), .bdSel(bdSel), .bdPage(bdPage), .bdOffs(bdOffs), .bdData(bdData)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(int sel, int pg, int off);
    return 8'((pg * 37) ^ (off * 5) ^ (sel * 90) ^ (off >> 3) ^ 8'h3C);
  endfunction

  function automatic int opSel(logic [7:0] op);
    if (op == 8'hD4 || op == 8'h54) return 1;
    if (op == 8'hD6 || op == 8'h56) return 2;
    return 0;
  endfunction

  function automatic bit opTol(logic [7:0] op);
    return op == 8'hE8 || op == 8'hD4 || op == 8'hD6;
  endfunction

  function automatic logic [7:0] expByte(logic [7:0] op, int page, int off, int k);
    int sel = opSel(op);
    int p = (sel == 0) ? page % NP : 0;
    int o = (off > PB - 1) ? 0 : off;
    for (int i = 0; i < k; i++) begin
      if (o == PB - 1) begin
        o = 0;
        if (sel == 0) p = (p + 1) % NP;
      end else o++;
    end
    return pat(sel, p, o);
  endfunction

  function automatic string tagOf(logic [7:0] op, int page, int off);
    if (off > PB - 1) return "R6";
    if (opSel(op) != 0) return "R5 R12";
    if (page == NP - 1) return "R4";
    return "R1 R2 R3 R12";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b);
    sck = 1'b0; si = b; tick(HALF);
    sck = 1'b1; tick(HALF);
  endtask

  task automatic doRead(logic [7:0] op, int page, int off, int n, logic idleHi, string tag);
    logic [23:0] addr;
    logic [7:0] got;
    int sel = opSel(op);
    bit tol = opTol(op);
    addr = (sel == 0) ? {2'b00, 12'(page), 10'(off)} : {14'd0, 10'(off)};
    sck = idleHi; tick(HALF);
    csN = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) sendBit(op[i]);
    for (int i = 23; i >= 0; i--) sendBit(addr[i]);
    for (int i = 0; i < ((sel == 0) ? 32 : 8); i++) sendBit(1'b0);
    if (tol) check(soEn == 1'b1, "R7 start after last header rise", int'(soEn), 1);
    else     check(soEn == 1'b0, "R8 no output before falling edge", int'(soEn), 0);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        if (tol) begin
          got[b] = so;
          sck = 1'b0; tick(HALF);
          sck = 1'b1; tick(HALF);
        end else begin
          sck = 1'b0; tick(HALF);
          got[b] = so;
          sck = 1'b1; tick(HALF);
        end
      end
      check(got == expByte(op, page, off, k), tag, int'(got), int'(expByte(op, page, off, k)));
    end
    csN = 1'b1; tick(1);
    check(soEn == 1'b0, "R9 enable drops with select", int'(soEn), 0);
    sck = idleHi; tick(2 * HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit seen;
    tick(5);
    check(soEn == 1'b0 && so == 1'b0, "R11 reset quiet", int'({soEn, so}), 0);
    rstN = 1'b1;
    tick(3);
    // R12: load array pages and both buffers through the backdoor
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < ((s == 0) ? NP : 1); p++)
        for (int o = 0; o < PB; o++) begin
          bdWe = 1'b1; bdSel = 2'(s); bdPage = 12'(p); bdOffs = 10'(o);
          bdData = pat(s, p, o);
          tick(1);
        end
    bdWe = 1'b0;
    tick(4);
    check(soEn == 1'b0, "R11 idle after load", int'(soEn), 0);

    for (int v = 0; v < NVEC; v++)
      doRead(VEC[v][36:29], int'(VEC[v][28:17]), int'(VEC[v][16:7]), int'(VEC[v][6:1]),
             VEC[v][0], tagOf(VEC[v][36:29], int'(VEC[v][28:17]), int'(VEC[v][16:7])));

    // R10: unknown opcode never enables the output
    seen = 1'b0;
    sck = 1'b0; tick(HALF);
    csN = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) begin sendBit(8'h0B >> i); seen |= soEn; end
    for (int i = 0; i < 72; i++) begin sendBit(1'b1); seen |= soEn; end
    check(!seen, "R10 unknown opcode stays silent", int'(seen), 0);
    csN = 1'b1; tick(2 * HALF);

    // R9: abort part way through a header, then a fresh command decodes
    csN = 1'b0; tick(HALF);
    for (int i = 7; i >= 0; i--) sendBit(8'hE8 >> i);
    for (int i = 0; i < 10; i++) sendBit(1'b1);
    csN = 1'b1; tick(1);
    check(soEn == 1'b0, "R9 abort leaves output off", int'(soEn), 0);
    tick(2 * HALF);
    doRead(8'hD6, 0, 5, 2, 1'b0, "R9 fresh command after abort");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule